// File: doc/BRIEF.md
# Sequenced Operand Router

This block is a per-tile router that moves 32-bit operand words between five ports: the local processor and the north, east, south and west neighbour links. It runs its own small program from a 256-entry instruction memory. Each instruction is a route that sets both crossbars for one step, an unconditional jump, or a branch that takes a word from a chosen input and jumps when the word is zero. A branch on a word lets several tiles follow the same control decision.

Every port carries two independent channels, and each channel has a crossbar of its own. A word arriving on a link is registered at the tile edge, then placed in a 4-entry input FIFO. A route pops the selected input FIFOs and pushes into one or more 4-entry output FIFOs. Flow control comes only from stalling: an instruction runs as a whole or waits. The program is written through a separate write port while reset is held.

Top module: `operand_route_seq`

## Requirements
- R1: While reset is held, and on the first clock edge after it is released, every output FIFO is empty (`outValid` all 0), every `linkReady` is 1, and execution starts at address 0.
- R2: A word presented with `linkValid` at clock edge k is captured in the boundary register at edge k, enters the input FIFO at edge k+1, and is pushed to its destination at edge k+2 at the earliest. `outValid` rises after edge k+2 and not before.
- R3: A route move whose destination mask has several bits set copies one popped word into every selected output FIFO of that channel in the same cycle.
- R4: Crossbar 0 connects only channel-0 inputs to channel-0 outputs, and crossbar 1 only channel-1 to channel-1. Both crossbars move in the same cycle when one instruction uses both.
- R5: Words between any input and output pair arrive in the order they were sent. A valid output word stays stable until `outTake` pops it.
- R6: An instruction stalls while any input FIFO it reads is empty or any output FIFO it writes holds 4 words. No word is lost or duplicated. `linkReady` is 0 while the input FIFO plus its boundary register hold 4 words.
- R7: An instruction is atomic. If any move in either crossbar cannot proceed, no FIFO is popped or pushed and the program counter holds.
- R8: Branch-if-zero (opcode 2) waits for a word on input channel bit[31], port code bits[30:28], and pops that word. It goes to the target in bits[7:0] when the word is zero, and to the next address otherwise. Jump (opcode 1) goes to the target in bits[7:0].
- R9: A route in which both moves of one crossbar field name the same destination is a no-operation. It pops nothing, pushes nothing and advances the program counter.
- R10: Instruction memory writes (`imWe`, `imAddr`, `imData`) take effect only while `rst_n` is 0. They are ignored while the router runs.
- R11: Instruction layout: bits[33:32] hold the opcode (0 route, 1 jump, 2 branch-if-zero, 3 no-operation). In a route, bits[15:0] drive crossbar 0 and bits[31:16] drive crossbar 1. A crossbar field holds move A (source code [15:13], destination mask [12:8]) and move B (source [7:5], mask [4:0]). Source codes: 1 processor, 2 north, 3 east, 4 south, 5 west; any other code means no move. Mask and array bit index: 0 processor, 1 north, 2 east, 3 south, 4 west.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the program-load window |
| imWe | input | 1 | Instruction memory write enable |
| imAddr | input | 8 | Instruction memory write address |
| imData | input | 34 | Instruction word to write |
| linkValid | input | 2x5 | Incoming word valid per channel and port |
| linkData | input | 2x5x32 | Incoming word per channel and port |
| linkReady | output | 2x5 | Sender may present a word on this channel and port |
| outValid | output | 2x5 | Output FIFO holds a word |
| outData | output | 2x5x32 | Head word of each output FIFO |
| outTake | input | 2x5 | Consumer pops the head word |

## Verification
The bench counts edges from a link push to the output to catch a boundary register that is missing or doubled, or an input FIFO that passes a word straight through. It gives an instruction only half of its operands, within one crossbar and across both. A router that moved part of an instruction would show a word early on one output. It fills the output and input FIFOs against a consumer that does not take, to expose lost words, an extra accepted word or reordering. It checks that a branch pops its condition word, that a duplicate-destination route leaves both source queues untouched for later instructions, and that a write to instruction memory while running changes nothing.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int NPORT   = 5;
  localparam int NCH     = 2;
  localparam int SRC_W   = 3;
  localparam int MASK_W  = NPORT;
  localparam int MOVE_W  = SRC_W + MASK_W;
  localparam int XF_W    = 2 * MOVE_W;
  localparam int OP_W    = 2;
  localparam int INSTR_W = OP_W + NCH * XF_W;

  localparam logic [OP_W-1:0] OP_ROUTE = 2'd0;
  localparam logic [OP_W-1:0] OP_JUMP  = 2'd1;
  localparam logic [OP_W-1:0] OP_BZ    = 2'd2;
  localparam logic [OP_W-1:0] OP_NOP   = 2'd3;

  typedef logic [NCH-1:0][NPORT-1:0] chport_t;

  typedef struct packed {
    chport_t                                popIn;
    chport_t                                pushOut;
    logic [NCH-1:0][NPORT-1:0][SRC_W-1:0]   selSrc;
  } strobe_t;

  function automatic logic srcOk(input logic [SRC_W-1:0] code);
    return (code >= SRC_W'(1)) && (code <= SRC_W'(NPORT));
  endfunction
endpackage

// File: rtl/opr_fifo.sv
module opr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/opr_datapath.sv
module opr_datapath import opr_pkg::*; #(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  chport_t                              linkValid,
  input  logic [NCH-1:0][NPORT-1:0][WORD_W-1:0] linkData,
  output chport_t                              linkReady,
  output chport_t                              outValid,
  output logic [NCH-1:0][NPORT-1:0][WORD_W-1:0] outData,
  input  chport_t                              outTake,
  input  strobe_t                              strb,
  output chport_t                              inEmpty,
  output chport_t                              outFull,
  output chport_t                              headZero
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [NCH-1:0][NPORT-1:0][WORD_W-1:0] inHead;
  logic [NCH-1:0][NPORT-1:0][WORD_W-1:0] xbarOut;
  logic [NCH-1:0][NPORT-1:0][CW-1:0]     inCount;
  chport_t                               bValid;
  logic [NCH-1:0][NPORT-1:0][WORD_W-1:0] bData;
  chport_t                               inFull;
  chport_t                               outEmpty;
  logic [NCH-1:0][NPORT-1:0][CW-1:0]     outCount;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      // link word is registered at the tile edge before the FIFO
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bValid[c][p] <= 1'b0;
          bData[c][p]  <= '0;
        end else begin
          bValid[c][p] <= linkValid[c][p];
          bData[c][p]  <= linkData[c][p];
        end
      end

      opr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_inq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (bValid[c][p]),
        .din   (bData[c][p]),
        .pop   (strb.popIn[c][p]),
        .dout  (inHead[c][p]),
        .count (inCount[c][p]),
        .empty (inEmpty[c][p]),
        .full  (inFull[c][p])
      );

      assign linkReady[c][p] =
        ({1'b0, inCount[c][p]} + (CW+1)'(bValid[c][p])) < (CW+1)'(FIFO_DEPTH);
      assign headZero[c][p]  = (inHead[c][p] == '0);

      // crossbar column: pick the source for this destination
      always_comb begin
        xbarOut[c][p] = '0;
        for (int s = 0; s < NPORT; s++) begin
          if (strb.selSrc[c][p] == SRC_W'(s + 1)) xbarOut[c][p] = inHead[c][s];
        end
      end

      opr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_outq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (strb.pushOut[c][p]),
        .din   (xbarOut[c][p]),
        .pop   (outTake[c][p] & ~outEmpty[c][p]),
        .dout  (outData[c][p]),
        .count (outCount[c][p]),
        .empty (outEmpty[c][p]),
        .full  (outFull[c][p])
      );

      assign outValid[c][p] = ~outEmpty[c][p];
    end
  end
endmodule

// File: rtl/opr_control.sv
module opr_control import opr_pkg::*; #(
  parameter int IMEM_AW = 8,
  localparam int IMEM_DEPTH = 1 << IMEM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               imWe,
  input  logic [IMEM_AW-1:0] imAddr,
  input  logic [INSTR_W-1:0] imData,
  input  chport_t            inEmpty,
  input  chport_t            outFull,
  input  chport_t            headZero,
  output strobe_t            strb,
  output logic               stall,
  output logic [IMEM_AW-1:0] pc
);
  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [INSTR_W-1:0] instr;
  logic [OP_W-1:0]    op;
  logic [IMEM_AW-1:0] pcNext, target;

  logic [NCH-1:0][SRC_W-1:0] srcA, srcB;
  chport_t                   effA, effB;
  logic                      dupDest;
  strobe_t                   rt;

  logic               brCh;
  logic [SRC_W-1:0]   brCode;
  logic               brEmpty, brZero;

  // program is loaded only while the router is held in reset
  always_ff @(posedge clk) begin
    if (!rst_n && imWe) imem[imAddr] <= imData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pcNext;
  end

  assign instr  = imem[pc];
  assign op     = instr[INSTR_W-1 -: OP_W];
  assign target = instr[IMEM_AW-1:0];
  assign brCh   = instr[31];
  assign brCode = instr[30:28];

  // route field decode, per crossbar
  always_comb begin
    dupDest = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      srcA[c] = instr[c*XF_W + XF_W - 1 -: SRC_W];
      srcB[c] = instr[c*XF_W + MOVE_W - 1 -: SRC_W];
      effA[c] = srcOk(srcA[c]) ? instr[c*XF_W + MOVE_W + MASK_W - 1 -: MASK_W] : '0;
      effB[c] = srcOk(srcB[c]) ? instr[c*XF_W + MASK_W - 1 -: MASK_W] : '0;
      dupDest = dupDest | (|(effA[c] & effB[c]));
    end
  end

  always_comb begin
    rt = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int d = 0; d < NPORT; d++) begin
        if (effA[c][d])      rt.selSrc[c][d] = srcA[c];
        else if (effB[c][d]) rt.selSrc[c][d] = srcB[c];
        rt.pushOut[c][d] = effA[c][d] | effB[c][d];
      end
      for (int s = 0; s < NPORT; s++) begin
        rt.popIn[c][s] = ((effA[c] != '0) && (srcA[c] == SRC_W'(s + 1))) ||
                         ((effB[c] != '0) && (srcB[c] == SRC_W'(s + 1)));
      end
    end
  end

  // branch source lookup
  always_comb begin
    brEmpty = 1'b1;
    brZero  = 1'b0;
    for (int s = 0; s < NPORT; s++) begin
      if (brCode == SRC_W'(s + 1)) begin
        brEmpty = inEmpty[brCh][s];
        brZero  = headZero[brCh][s];
      end
    end
  end

  // sequencing and stall
  always_comb begin
    strb   = '0;
    stall  = 1'b0;
    pcNext = pc + 1'b1;
    unique case (op)
      OP_ROUTE: begin
        if (!dupDest) begin
          if ((|(rt.popIn & inEmpty)) || (|(rt.pushOut & outFull))) begin
            stall  = 1'b1;
            pcNext = pc;
          end else begin
            strb = rt;
          end
        end
      end
      OP_JUMP: pcNext = target;
      OP_BZ: begin
        if (srcOk(brCode)) begin
          if (brEmpty) begin
            stall  = 1'b1;
            pcNext = pc;
          end else begin
            for (int s = 0; s < NPORT; s++) begin
              if (brCode == SRC_W'(s + 1)) strb.popIn[brCh][s] = 1'b1;
            end
            if (brZero) pcNext = target;
          end
        end
      end
      default: pcNext = pc + 1'b1;
    endcase
  end
endmodule

// File: rtl/operand_route_seq.sv
module operand_route_seq import opr_pkg::*; #(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int IMEM_AW    = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  imWe,
  input  logic [IMEM_AW-1:0]                    imAddr,
  input  logic [INSTR_W-1:0]                    imData,
  input  logic [NCH-1:0][NPORT-1:0]             linkValid,
  input  logic [NCH-1:0][NPORT-1:0][WORD_W-1:0] linkData,
  output logic [NCH-1:0][NPORT-1:0]             linkReady,
  output logic [NCH-1:0][NPORT-1:0]             outValid,
  output logic [NCH-1:0][NPORT-1:0][WORD_W-1:0] outData,
  input  logic [NCH-1:0][NPORT-1:0]             outTake
);
  strobe_t            strb;
  chport_t            inEmpty, outFull, headZero;
  logic               stall;
  logic [IMEM_AW-1:0] pc;

  opr_control #(.IMEM_AW(IMEM_AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .imWe     (imWe),
    .imAddr   (imAddr),
    .imData   (imData),
    .inEmpty  (inEmpty),
    .outFull  (outFull),
    .headZero (headZero),
    .strb     (strb),
    .stall    (stall),
    .pc       (pc)
  );

  opr_datapath #(.WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .linkValid (linkValid),
    .linkData  (linkData),
    .linkReady (linkReady),
    .outValid  (outValid),
    .outData   (outData),
    .outTake   (outTake),
    .strb      (strb),
    .inEmpty   (inEmpty),
    .outFull   (outFull),
    .headZero  (headZero)
  );
endmodule

// File: rtl/operand_route_seq_chk.sv
module operand_route_seq_chk import opr_pkg::*; #(
  parameter int WORD_W = 32
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [NCH-1:0][NPORT-1:0]             linkReady,
  input logic [NCH-1:0][NPORT-1:0]             outValid,
  input logic [NCH-1:0][NPORT-1:0][WORD_W-1:0] outData,
  input logic [NCH-1:0][NPORT-1:0]             outTake,
  input strobe_t                               strb,
  input chport_t                               inEmpty,
  input chport_t                               outFull,
  input logic                                  stall
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (outValid == '0) && (linkReady == '1));

  // R7
  stall_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (strb.popIn == '0) && (strb.pushOut == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    for (genvar p = 0; p < NPORT; p++) begin : g_p
      // R6
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb.pushOut[c][p] |-> !outFull[c][p]);

      // R6
      no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb.popIn[c][p] |-> !inEmpty[c][p]);

      // R7
      push_has_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb.pushOut[c][p] |-> (strb.selSrc[c][p] != '0) &&
                               strb.popIn[c][strb.selSrc[c][p] - 3'd1]);

      // R5
      out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outValid[c][p] && !outTake[c][p]) |=> outValid[c][p] && $stable(outData[c][p]));
    end
  end
endmodule

bind operand_route_seq operand_route_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .linkReady (linkReady),
  .outValid  (outValid),
  .outData   (outData),
  .outTake   (outTake),
  .strb      (strb),
  .inEmpty   (inEmpty),
  .outFull   (outFull),
  .stall     (stall)
);

// File: tb/operand_route_seq_tb.sv
`timescale 1ns/1ps
module operand_route_seq_tb;
  localparam int CP = 1, CN = 2, CE = 3, CS = 4, CW_ = 5;   // source codes (R11)
  localparam int IP = 0, IN = 1, IE = 2, IS = 3, IW = 4;    // bit indices (R11)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic imWe = 1'b0;
  logic [7:0] imAddr = '0;
  logic [33:0] imData = '0;
  logic [1:0][4:0] linkValid = '0;
  logic [1:0][4:0][31:0] linkData = '0;
  logic [1:0][4:0] linkReady;
  logic [1:0][4:0] outValid;
  logic [1:0][4:0][31:0] outData;
  logic [1:0][4:0] outTake = '0;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;

  always #2 clk = ~clk;   // 250 MHz

  operand_route_seq u_dut (
    .clk(clk), .rst_n(rst_n), .imWe(imWe), .imAddr(imAddr), .imData(imData),
    .linkValid(linkValid), .linkData(linkData), .linkReady(linkReady),
    .outValid(outValid), .outData(outData), .outTake(outTake)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nBad = nBad + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  // R11 encoders
  function automatic logic [15:0] fld(int sa, int ma, int sb, int mb);
    return {3'(sa), 5'(ma), 3'(sb), 5'(mb)};
  endfunction
  function automatic logic [33:0] route(logic [15:0] f1, logic [15:0] f0);
    return {2'd0, f1, f0};
  endfunction
  function automatic logic [33:0] jmp(int t);
    return {2'd1, 24'd0, 8'(t)};
  endfunction
  function automatic logic [33:0] bz(int ch, int code, int t);
    return {2'd2, 1'(ch), 3'(code), 20'd0, 8'(t)};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic enterReset();
    @(negedge clk);
    rst_n = 1'b0;
    linkValid = '0;
    outTake = '0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [33:0] w);
    imWe = 1'b1; imAddr = 8'(a); imData = w;
    @(negedge clk);
    imWe = 1'b0;
  endtask

  task automatic leaveReset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int c, input int p, input logic [31:0] d);
    while (!linkReady[c][p]) @(negedge clk);
    linkValid[c][p] = 1'b1;
    linkData[c][p] = d;
    @(negedge clk);
    linkValid[c][p] = 1'b0;
  endtask

  task automatic expectWord(input int c, input int p, input logic [31:0] exp,
                            input string tag);
    for (int i = 0; i < 40 && !outValid[c][p]; i++) @(negedge clk);
    check(outValid[c][p] && outData[c][p] == exp, tag, outData[c][p], exp);
    outTake[c][p] = 1'b1;
    @(negedge clk);
    outTake[c][p] = 1'b0;
  endtask

  task automatic expectIdle(input int c, input int p, input string tag);
    check(!outValid[c][p], tag, 32'(outValid[c][p]), 32'd0);
  endtask

  // R1, R2, R4: reset state and edge-exact latency
  task automatic t_latency();
    enterReset();
    wr(0, route(16'd0, fld(CW_, 1 << IP, 0, 0)));
    wr(1, jmp(0));
    check(outValid == '0, "R1 outputs empty in reset", 32'(outValid), 0);
    leaveReset();
    check(outValid == '0 && linkReady == '1, "R1 idle after reset",
          32'(linkReady), 32'h3ff);
    linkValid[0][IW] = 1'b1; linkData[0][IW] = 32'hA5A5_0001;
    @(negedge clk);                                   // edge k passed
    linkValid[0][IW] = 1'b0;
    check(!outValid[0][IP], "R2 no output after edge k", 32'(outValid[0][IP]), 0);
    @(negedge clk);                                   // edge k+1
    check(!outValid[0][IP], "R2 no fall-through at k+1", 32'(outValid[0][IP]), 0);
    @(negedge clk);                                   // edge k+2
    check(outValid[0][IP] && outData[0][IP] == 32'hA5A5_0001, "R2 word at k+2",
          outData[0][IP], 32'hA5A5_0001);
    expectIdle(1, IP, "R4 channel 1 untouched");
    expectWord(0, IP, 32'hA5A5_0001, "R2 take");
  endtask

  // R3: multicast
  task automatic t_multicast();
    enterReset();
    wr(0, route(16'd0, fld(CP, (1 << IE) | (1 << IS), 0, 0)));
    wr(1, jmp(0));
    leaveReset();
    send(0, IP, 32'h1111_0000);
    send(0, IP, 32'h1111_0001);
    expectWord(0, IE, 32'h1111_0000, "R3 east copy 0");
    expectWord(0, IS, 32'h1111_0000, "R3 south copy 0");
    expectWord(0, IE, 32'h1111_0001, "R3 east copy 1");
    expectWord(0, IS, 32'h1111_0001, "R3 south copy 1");
    expectIdle(0, IN, "R3 north not selected");
    expectIdle(0, IW, "R3 west not selected");
  endtask

  // R4, R7: both crossbars in one instruction, all or nothing
  task automatic t_dual();
    enterReset();
    wr(0, route(fld(CS, 1 << IN, 0, 0), fld(CN, 1 << IS, 0, 0)));
    wr(1, jmp(0));
    leaveReset();
    send(1, IS, 32'h2222_0001);
    repeat (6) @(negedge clk);
    expectIdle(1, IN, "R7 crossbar 1 waits for crossbar 0");
    send(0, IN, 32'h2222_0000);
    for (int i = 0; i < 20 && !outValid[0][IS]; i++) @(negedge clk);
    check(outValid[0][IS] && outValid[1][IN], "R4 both crossbars same cycle",
          32'(outValid), 32'h0);
    expectWord(0, IS, 32'h2222_0000, "R4 crossbar 0 data");
    expectWord(1, IN, 32'h2222_0001, "R4 crossbar 1 data");
  endtask

  // R7: two moves in one crossbar, one source missing
  task automatic t_atomic();
    enterReset();
    wr(0, route(16'd0, fld(CP, 1 << IE, CN, 1 << IS)));
    wr(1, jmp(0));
    leaveReset();
    send(0, IP, 32'h3333_0000);
    repeat (6) @(negedge clk);
    expectIdle(0, IE, "R7 no partial move");
    send(0, IN, 32'h3333_0001);
    for (int i = 0; i < 20 && !outValid[0][IE]; i++) @(negedge clk);
    check(outValid[0][IE] && outValid[0][IS], "R7 moves land together",
          32'(outValid[0]), 32'(5'b01100));
    expectWord(0, IE, 32'h3333_0000, "R7 east data");
    expectWord(0, IS, 32'h3333_0001, "R7 south data");
  endtask

  // R5, R6: backpressure fill and in-order drain
  task automatic t_fill();
    int sent = 0;
    enterReset();
    wr(0, route(fld(CE, 1 << IW, 0, 0), 16'd0));
    wr(1, jmp(0));
    leaveReset();
    for (int i = 0; i < 40; i++) begin
      if (linkReady[1][IE] && sent < 20) begin
        linkValid[1][IE] = 1'b1;
        linkData[1][IE] = 32'h4444_0000 + 32'(sent);
        sent++;
      end else begin
        linkValid[1][IE] = 1'b0;
      end
      @(negedge clk);
    end
    linkValid[1][IE] = 1'b0;
    check(sent == 8, "R6 accepted words with output full", 32'(sent), 32'd8);
    check(!linkReady[1][IE], "R6 linkReady low when queue full",
          32'(linkReady[1][IE]), 0);
    for (int k = 0; k < 8; k++)
      expectWord(1, IW, 32'h4444_0000 + 32'(k), "R5 in-order drain");
    repeat (6) @(negedge clk);
    expectIdle(1, IW, "R6 nothing duplicated");
  endtask

  // R8: branch on a word taken from a port
  task automatic t_branch();
    enterReset();
    wr(0, bz(0, CP, 3));
    wr(1, route(16'd0, fld(CN, 1 << IE, 0, 0)));
    wr(2, jmp(0));
    wr(3, route(16'd0, fld(CN, 1 << IW, 0, 0)));
    wr(4, jmp(0));
    leaveReset();
    send(0, IP, 32'd0);
    send(0, IN, 32'h5555_0000);
    expectWord(0, IW, 32'h5555_0000, "R8 zero takes branch");
    expectIdle(0, IE, "R8 fall-through path unused");
    send(0, IP, 32'd5);
    send(0, IN, 32'h5555_0001);
    expectWord(0, IE, 32'h5555_0001, "R8 nonzero falls through");
    expectIdle(0, IW, "R8 condition word popped");
  endtask

  // R9: duplicate destination is a no-operation
  task automatic t_dup();
    enterReset();
    wr(0, route(16'd0, fld(CP, 1 << IE, CN, (1 << IE) | (1 << IS))));
    wr(1, route(16'd0, fld(CP, 1 << IS, 0, 0)));
    wr(2, route(16'd0, fld(CN, 1 << IW, 0, 0)));
    wr(3, jmp(3));
    leaveReset();
    send(0, IP, 32'h6666_0000);
    send(0, IN, 32'h6666_0001);
    expectWord(0, IS, 32'h6666_0000, "R9 next instruction gets P word");
    expectWord(0, IW, 32'h6666_0001, "R9 N word still queued");
    expectIdle(0, IE, "R9 no move to duplicated destination");
    expectIdle(0, IS, "R9 south single copy");
  endtask

  // R10: writes while running are ignored
  task automatic t_runwrite();
    enterReset();
    wr(0, route(16'd0, fld(CW_, 1 << IP, 0, 0)));
    wr(1, jmp(0));
    leaveReset();
    imWe = 1'b1; imAddr = 8'd0; imData = route(16'd0, fld(CW_, 1 << IS, 0, 0));
    @(negedge clk);
    imWe = 1'b0;
    send(0, IW, 32'h7777_0000);
    expectWord(0, IP, 32'h7777_0000, "R10 program unchanged");
    expectIdle(0, IS, "R10 written route not used");
  endtask

  initial begin
    t_latency();
    t_multicast();
    t_dual();
    t_atomic();
    t_fill();
    t_branch();
    t_dup();
    t_runwrite();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule